// File: doc/BRIEF.md
# Long-Instruction Control-Bit Sequencer

This block sits beside the fetch stage of a vector coprocessor that issues one 64-bit instruction pair per step. It looks only at the flag bits in the upper 32-bit word of each pair. From them it decides whether the coprocessor keeps running, whether the lower word is an instruction or a literal for the immediate register, and whether a debug or trace halt stops the program and raises an interrupt. It also keeps the program counter. The counter moves one pair at a time and takes a pending branch target after a single delay-slot pair. The target itself is computed elsewhere.

A program is started by a start pulse that carries the entry address. The program then advances on every issue strobe. It ends in one of two ways. An end flag ends it one pair late. An enabled debug or trace flag ends it at once, after the current pair. Each stop clears the running bit in the status word. A halt also records which kind of halt happened.

Top module: `seq_ctl_sequencer`

## Requirements
- R1: While reset is asserted, and after its release, running is low, the PC is zero, all status bits are zero, the interrupt output is low and the immediate register holds zero.
- R2: A start pulse while stopped sets running (status bit 8), loads the PC from the start address, and clears both halt bits in the next cycle. A start pulse while running has no effect.
- R3: Each pair issued while running advances the PC by 8, modulo 2^PC_W. An issue strobe while stopped changes nothing.
- R4: When bit 31 of the upper word is set on an issued pair, the immediate select is high and the lower-execute output is low in that cycle. The lower word is loaded into the immediate register. Any branch request in that pair is ignored.
- R5: When bit 30 of the upper word is set on an issued pair, the next issued pair still executes. Running then clears at the end of that pair.
- R6: Bit 28 of the upper word, with the debug enable high, stops the program after the current pair, sets status bit 9 and raises the interrupt. With the enable low, the bit has no effect.
- R7: Bit 27 of the upper word, with the trace enable high, stops the program after the current pair, sets status bit 10 and raises the interrupt. With the enable low, the bit has no effect.
- R8: A branch request on an issued pair does not redirect the PC on that pair. The following issued pair (the delay slot) loads the PC with the requested target instead of adding 8.
- R9: When several stop causes fall on one pair, or an enabled halt falls in an end-flag delay slot, the program stops after that pair. The interrupt is a single pulse lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command |
| start_pc_i | input | PC_W | Entry address loaded on start |
| issue_i | input | 1 | One instruction pair is executed this cycle |
| upper_i | input | WORD_W | Upper word of the issued pair |
| lower_i | input | WORD_W | Lower word of the issued pair |
| dbg_en_i | input | 1 | Debug-halt enable from the control register |
| trc_en_i | input | 1 | Trace-halt enable from the control register |
| branch_i | input | 1 | Taken branch in the lower slot of this pair |
| branch_tgt_i | input | PC_W | Byte address of that branch target |
| running_o | output | 1 | Program is running |
| pc_o | output | PC_W | Byte address of the next pair |
| status_o | output | 16 | Status word: bit 8 running, bit 9 debug halt, bit 10 trace halt |
| irq_o | output | 1 | Interrupt pulse on a debug or trace halt |
| imm_sel_o | output | 1 | Lower word is routed to the immediate register |
| lower_exec_o | output | 1 | Lower word executes as an instruction |
| imm_o | output | WORD_W | Immediate register |

## Verification
The bench builds the block with its defaults: PC_W of 14, a step of 8 and 32-bit words. With a 14-bit counter, a start at 0x3FF8 followed by one issue reaches the wrap to zero in two steps, so the modulo rule is tested directly. The pipelined cases are each placed right after a start: end delay slots, halts that coincide, and a branch on the last pair. This keeps every cause of a stop within a few table rows.

// File: rtl/seq_ctl_pkg.sv
package seq_ctl_pkg;
    localparam int FLAG_IMM   = 31;
    localparam int FLAG_END   = 30;
    localparam int FLAG_DBG   = 28;
    localparam int FLAG_TRC   = 27;
    localparam int STAT_W     = 16;
    localparam int STAT_RUN   = 8;
    localparam int STAT_DBG   = 9;
    localparam int STAT_TRC   = 10;

    typedef struct packed {
        logic imm;
        logic fin;
        logic dbg;
        logic trc;
    } ctl_flags_t;
endpackage

// File: rtl/seq_ctl_decode.sv
module seq_ctl_decode
    import seq_ctl_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] upper_i,
    input  logic              dbg_en_i,
    input  logic              trc_en_i,
    output ctl_flags_t        flags_o
);
    always_comb begin
        flags_o.imm = upper_i[FLAG_IMM];
        flags_o.fin = upper_i[FLAG_END];
        flags_o.dbg = upper_i[FLAG_DBG] & dbg_en_i;
        flags_o.trc = upper_i[FLAG_TRC] & trc_en_i;
    end
endmodule

// File: rtl/seq_ctl_pc_step.sv
module seq_ctl_pc_step #(
    parameter int PC_W    = 14,
    parameter int PC_STEP = 8
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            redirect_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] pc_next_o
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    always_comb begin
        if (redirect_i) pc_next_o = target_i;
        else            pc_next_o = pc_i + STEP_V;
    end
endmodule

// File: rtl/seq_ctl_sequencer.sv
module seq_ctl_sequencer
    import seq_ctl_pkg::*;
#(
    parameter int PC_W    = 14,
    parameter int PC_STEP = 8,
    parameter int WORD_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [PC_W-1:0]   start_pc_i,
    input  logic              issue_i,
    input  logic [WORD_W-1:0] upper_i,
    input  logic [WORD_W-1:0] lower_i,
    input  logic              dbg_en_i,
    input  logic              trc_en_i,
    input  logic              branch_i,
    input  logic [PC_W-1:0]   branch_tgt_i,
    output logic              running_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o,
    output logic              imm_sel_o,
    output logic              lower_exec_o,
    output logic [WORD_W-1:0] imm_o
);
    typedef struct packed {
        logic              running;
        logic [PC_W-1:0]   pc;
        logic              end_pend;
        logic              br_pend;
        logic [PC_W-1:0]   br_tgt;
        logic              dbg_hit;
        logic              trc_hit;
        logic              irq;
        logic [WORD_W-1:0] imm;
    } seq_state_t;

    seq_state_t  st_d, st_q;
    ctl_flags_t  flags;
    logic [PC_W-1:0] pc_next;
    logic        fire;
    logic        halt_now;
    logic        take_br;

    seq_ctl_decode #(.WORD_W(WORD_W)) u_decode (
        .upper_i  (upper_i),
        .dbg_en_i (dbg_en_i),
        .trc_en_i (trc_en_i),
        .flags_o  (flags)
    );

    seq_ctl_pc_step #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
        .pc_i       (st_q.pc),
        .redirect_i (st_q.br_pend),
        .target_i   (st_q.br_tgt),
        .pc_next_o  (pc_next)
    );

    assign fire     = issue_i & st_q.running;
    assign halt_now = flags.dbg | flags.trc | st_q.end_pend;
    assign take_br  = branch_i & ~flags.imm;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!st_q.running && start_i) begin
            st_d.running  = 1'b1;
            st_d.pc       = start_pc_i;
            st_d.end_pend = 1'b0;
            st_d.br_pend  = 1'b0;
            st_d.dbg_hit  = 1'b0;
            st_d.trc_hit  = 1'b0;
        end else if (fire) begin
            st_d.pc      = pc_next;
            st_d.br_pend = take_br;
            if (take_br)   st_d.br_tgt = branch_tgt_i;
            if (flags.imm) st_d.imm    = lower_i;
            st_d.end_pend = flags.fin & ~halt_now;
            st_d.dbg_hit  = st_q.dbg_hit | flags.dbg;
            st_d.trc_hit  = st_q.trc_hit | flags.trc;
            st_d.irq      = flags.dbg | flags.trc;
            if (halt_now) begin
                st_d.running  = 1'b0;
                st_d.end_pend = 1'b0;
                st_d.br_pend  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        status_o           = '0;
        status_o[STAT_RUN] = st_q.running;
        status_o[STAT_DBG] = st_q.dbg_hit;
        status_o[STAT_TRC] = st_q.trc_hit;
    end

    assign running_o    = st_q.running;
    assign pc_o         = st_q.pc;
    assign irq_o        = st_q.irq;
    assign imm_o        = st_q.imm;
    assign imm_sel_o    = fire & flags.imm;
    assign lower_exec_o = fire & ~flags.imm;
endmodule

// File: rtl/seq_ctl_checks.sv
module seq_ctl_checks #(
    parameter int PC_W = 14
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic [PC_W-1:0] start_pc_i,
    input logic            issue_i,
    input logic            running_o,
    input logic [PC_W-1:0] pc_o,
    input logic [15:0]     status_o,
    input logic            irq_o,
    input logic            imm_sel_o,
    input logic            lower_exec_o
);
    assert_start_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !running_o) |=> (running_o && pc_o == $past(start_pc_i)));

    assert_pc_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(issue_i && running_o) && !start_i) |=> $stable(pc_o));

    assert_slot_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(imm_sel_o && lower_exec_o) && ((imm_sel_o || lower_exec_o) -> running_o));

    assert_stop_on_issue_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(running_o) |-> $past(issue_i));

    assert_dbg_halt_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[9]) |-> (!running_o && irq_o));

    assert_trc_halt_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[10]) |-> (!running_o && irq_o));

    assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    assert_irq_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ($past(issue_i) && !running_o));
endmodule

bind seq_ctl_sequencer seq_ctl_checks #(.PC_W(PC_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_pc_i   (start_pc_i),
    .issue_i      (issue_i),
    .running_o    (running_o),
    .pc_o         (pc_o),
    .status_o     (status_o),
    .irq_o        (irq_o),
    .imm_sel_o    (imm_sel_o),
    .lower_exec_o (lower_exec_o)
);

// File: tb/sim_seq_ctl_sequencer.sv
module sim_seq_ctl_sequencer;
    localparam int PERIOD = 10;
    localparam int PC_W   = 14;
    localparam int NVEC   = 24;

    typedef struct packed {
        logic        st;
        logic        iss;
        logic [13:0] spc;
        logic [31:0] up;
        logic [31:0] lo;
        logic        den;
        logic        ten;
        logic        br;
        logic [13:0] tgt;
        logic        erun;
        logic [13:0] epc;
        logic        eirq;
        logic [2:0]  estt;
        logic [31:0] eimm;
    } vec_t;

    // estt = {trace halt, debug halt, running}
    localparam vec_t TBL [0:NVEC-1] = '{
        '{1'b1,1'b0,14'h100,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,  1'b1,14'h100,1'b0,3'b001,32'h0},
        '{1'b0,1'b1,14'h0,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,    1'b1,14'h108,1'b0,3'b001,32'h0},
        '{1'b0,1'b1,14'h0,32'h8000_0000,32'hDEAD_BEEF,1'b0,1'b0,1'b1,14'h040, 1'b1,14'h110,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h0,32'h1234,1'b0,1'b0,1'b1,14'h200, 1'b1,14'h118,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,    1'b1,14'h200,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h4000_0000,32'h0,1'b0,1'b0,1'b0,14'h0, 1'b1,14'h208,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,    1'b0,14'h210,1'b0,3'b000,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h8000_0000,32'h5555,1'b0,1'b0,1'b0,14'h0, 1'b0,14'h210,1'b0,3'b000,32'hDEAD_BEEF},
        '{1'b1,1'b0,14'h3FF8,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0, 1'b1,14'h3FF8,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,    1'b1,14'h0000,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h1000_0000,32'h0,1'b0,1'b0,1'b0,14'h0, 1'b1,14'h0008,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h0800_0000,32'h0,1'b0,1'b0,1'b0,14'h0, 1'b1,14'h0010,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h1000_0000,32'h0,1'b1,1'b0,1'b0,14'h0, 1'b0,14'h0018,1'b1,3'b010,32'hDEAD_BEEF},
        '{1'b1,1'b0,14'h080,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,  1'b1,14'h0080,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h0800_0000,32'h0,1'b0,1'b1,1'b0,14'h0, 1'b0,14'h0088,1'b1,3'b100,32'hDEAD_BEEF},
        '{1'b1,1'b0,14'h0,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,    1'b1,14'h0000,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h5800_0000,32'h0,1'b1,1'b1,1'b0,14'h0, 1'b0,14'h0008,1'b1,3'b110,32'hDEAD_BEEF},
        '{1'b1,1'b0,14'h0,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,    1'b1,14'h0000,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h4000_0000,32'h0,1'b0,1'b0,1'b0,14'h0, 1'b1,14'h0008,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h1000_0000,32'h0,1'b1,1'b0,1'b0,14'h0, 1'b0,14'h0010,1'b1,3'b010,32'hDEAD_BEEF},
        '{1'b1,1'b0,14'h040,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,  1'b1,14'h0040,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b1,1'b0,14'h300,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,  1'b1,14'h0040,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h4000_0000,32'h0,1'b0,1'b0,1'b1,14'h120, 1'b1,14'h0048,1'b0,3'b001,32'hDEAD_BEEF},
        '{1'b0,1'b1,14'h0,32'h0,32'h0,1'b0,1'b0,1'b0,14'h0,    1'b0,14'h0120,1'b0,3'b000,32'hDEAD_BEEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [13:0] start_pc = '0;
    logic        issue = 1'b0;
    logic [31:0] upper = '0;
    logic [31:0] lower = '0;
    logic        dbg_en = 1'b0;
    logic        trc_en = 1'b0;
    logic        branch = 1'b0;
    logic [13:0] branch_tgt = '0;
    logic        running;
    logic [13:0] pc;
    logic [15:0] status;
    logic        irq;
    logic        imm_sel;
    logic        lower_exec;
    logic [31:0] imm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    seq_ctl_sequencer #(.PC_W(PC_W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_pc_i(start_pc),
        .issue_i(issue), .upper_i(upper), .lower_i(lower),
        .dbg_en_i(dbg_en), .trc_en_i(trc_en), .branch_i(branch),
        .branch_tgt_i(branch_tgt), .running_o(running), .pc_o(pc),
        .status_o(status), .irq_o(irq), .imm_sel_o(imm_sel),
        .lower_exec_o(lower_exec), .imm_o(imm)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD*20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic prev_run;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 running", 64'(running), 64'd0);
        chk("R1 pc", 64'(pc), 64'd0);
        chk("R1 status", 64'(status), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 imm", 64'(imm), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 running after release", 64'(running), 64'd0);
        prev_run = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            start = TBL[i].st;  start_pc = TBL[i].spc;  issue = TBL[i].iss;
            upper = TBL[i].up;  lower = TBL[i].lo;
            dbg_en = TBL[i].den; trc_en = TBL[i].ten;
            branch = TBL[i].br;  branch_tgt = TBL[i].tgt;
            #1;
            // R4 slot routing, gated by running state before this pair
            chk($sformatf("R4 imm_sel v%0d", i), 64'(imm_sel),
                64'(TBL[i].iss & prev_run & TBL[i].up[31]));
            chk($sformatf("R4 lower_exec v%0d", i), 64'(lower_exec),
                64'(TBL[i].iss & prev_run & ~TBL[i].up[31]));
            @(posedge clk);
            #1;
            // R2 R3 R5 R6 R7 R8 R9 depending on row
            chk($sformatf("R3 R8 pc v%0d", i), 64'(pc), 64'(TBL[i].epc));
            chk($sformatf("R2 R5 running v%0d", i), 64'(running), 64'(TBL[i].erun));
            chk($sformatf("R6 R7 status v%0d", i), 64'(status),
                64'({5'b0, TBL[i].estt, 8'b0}));
            chk($sformatf("R9 irq v%0d", i), 64'(irq), 64'(TBL[i].eirq));
            chk($sformatf("R4 imm v%0d", i), 64'(imm), 64'(TBL[i].eimm));
            prev_run = TBL[i].erun;
        end
        @(negedge clk);
        start = 1'b0; issue = 1'b0; upper = '0; branch = 1'b0;
        #1;
        chk("R9 irq pulse ended", 64'(irq), 64'd0);
        // R2 restart, then R1 reset while running
        start = 1'b1; start_pc = 14'h0200;
        @(negedge clk);
        start = 1'b0;
        chk("R2 restart running", 64'(running), 64'd1);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset running", 64'(running), 64'd0);
        chk("R1 async reset pc", 64'(pc), 64'd0);
        chk("R1 async reset imm", 64'(imm), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule